// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block collects thirty-two level-sensitive interrupt sources and presents them to a processor as two interrupt lines. Software sees it through a single 32-bit register port with a byte address, a write strobe, write data and combinational read data. Each source has its own mask bit. The mask is never written directly. One register offset sets mask bits where the written word has ones, and a second offset clears them. A routing register chooses which of the two output lines each source drives.

Source levels are captured into a register on every clock, and software can read that sampled raw view. Two per-line status words show the sources that are both unmasked and routed to that line. Bit 31 of the mask register has two jobs. It is the mask bit for source 31, and it is also a global gate on both output lines. An output line is high while its status word is nonzero and the gate is open. It falls as soon as the contributing sources go low or are masked, because nothing is latched.

Top module: `irqc_top`

## Requirements
- R1: After synchronous reset, the mask register, the routing register and both interrupt lines are all zero.
- R2: A write to byte offset 0x34 sets every mask bit whose written bit is 1 and leaves the other mask bits unchanged. Reads at 0x34 and at 0x38 both return the current mask.
- R3: A write to byte offset 0x38 clears every mask bit whose written bit is 1. Writing all ones clears the whole mask, including bit 31.
- R4: Byte offset 0x20 holds the routing word, which can be written and read back. A routing bit of 0 sends its source to line 0, and a routing bit of 1 sends it to line 1.
- R5: A read at byte offset 0x30 returns the source levels sampled at the previous rising clock edge, whatever the mask holds.
- R6: A read at 0x00 returns raw AND mask AND NOT routing. A read at 0x04 returns raw AND mask AND routing.
- R7: irq_o[n] is 1 exactly when status word n is nonzero and mask bit 31 (the global gate) is 1. It rises at the first clock edge after a source goes high, and it falls at the first clock edge after that source goes low.
- R8: A read at any offset other than 0x00, 0x04, 0x20, 0x30, 0x34 or 0x38 returns zero. Writes to 0x00, 0x04, 0x30 or an unmapped offset change neither the mask nor the routing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 32 | Level interrupt sources |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 2 | Interrupt lines 0 and 1 |

## Verification
The bench writes zero to the set offset and checks that the mask is unchanged. If zero bits were treated as clears, mask bits would be lost. It closes the global gate while status is still nonzero and checks that both lines drop, while the status words stay visible to software. If bit 31 acted only as an ordinary source mask, the lines would stay high. It writes to the status, raw and unmapped offsets and checks that the mask and the routing word are unchanged. A decoder that aliased those offsets would corrupt the routing. It also samples the interrupt line just before and just after the clock edge that follows a source change, which exposes an extra or a missing pipeline stage.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_W      = 32;
    localparam int ADDR_W     = 8;
    localparam int NUM_OUT    = 2;
    localparam int GATE_BIT   = SRC_W - 1;

    localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h38;

    typedef enum logic [2:0] {
        SEL_STAT0,
        SEL_STAT1,
        SEL_ROUTE,
        SEL_RAW,
        SEL_SET,
        SEL_CLR,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [SRC_W-1:0] mask;
        logic [SRC_W-1:0] route;
    } ctrl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_STAT0: s = SEL_STAT0;
            OFS_STAT1: s = SEL_STAT1;
            OFS_ROUTE: s = SEL_ROUTE;
            OFS_RAW:   s = SEL_RAW;
            OFS_SET:   s = SEL_SET;
            OFS_CLR:   s = SEL_CLR;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irqc_sampler.sv
module irqc_sampler
    import irqc_pkg::*;
#(
    parameter int W = SRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src,
    output logic [W-1:0] raw
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) raw[i] <= 1'b0;
            else     raw[i] <= src[i];
        end
    end

    // R5: the raw view trails the sources by exactly one edge
    assert_raw_follow_R5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> raw == $past(src));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [SRC_W-1:0] wr_data,
    output ctrl_t            ctrl
);
    ctrl_t ctrl_q, ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            case (sel)
                SEL_SET:   ctrl_d.mask  = ctrl_q.mask | wr_data;
                SEL_CLR:   ctrl_d.mask  = ctrl_q.mask & ~wr_data;
                SEL_ROUTE: ctrl_d.route = wr_data;
                default:   ctrl_d = ctrl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    assert_mask_set_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_SET) |=> ctrl.mask == ($past(ctrl.mask) | $past(wr_data)));
    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_CLR) |=> ctrl.mask == ($past(ctrl.mask) & ~$past(wr_data)));
    assert_route_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_ROUTE) |=> ctrl.route == $past(wr_data));
    assert_mask_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (sel == SEL_SET || sel == SEL_CLR)) |=> $stable(ctrl.mask));
    assert_route_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_ROUTE) |=> $stable(ctrl.route));
endmodule

// File: rtl/irqc_route.sv
module irqc_route
    import irqc_pkg::*;
(
    input  logic [SRC_W-1:0] raw,
    input  ctrl_t            ctrl,
    output logic [SRC_W-1:0] status [NUM_OUT],
    output logic [NUM_OUT-1:0] irq
);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        logic [SRC_W-1:0] sel_bits;
        if (o == 0) begin : g_zero
            assign sel_bits = ~ctrl.route;
        end else begin : g_one
            assign sel_bits = ctrl.route;
        end
        assign status[o] = raw & ctrl.mask & sel_bits;
        assign irq[o]    = (|status[o]) & ctrl.mask[GATE_BIT];
    end

    // R6: a source can never appear on both lines
    always_comb begin
        assert_disjoint_R6: assert ((status[0] & status[1]) == '0);
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [SRC_W-1:0]  wr_data_i,
    output logic [SRC_W-1:0]  rd_data_o,
    output logic [NUM_OUT-1:0] irq_o
);
    reg_sel_e         sel;
    ctrl_t            ctrl;
    logic [SRC_W-1:0] raw;
    logic [SRC_W-1:0] status [NUM_OUT];

    assign sel = decode_addr(addr_i);

    irqc_sampler #(.W(SRC_W)) u_sampler (
        .clk (clk),
        .rst (rst),
        .src (src_i),
        .raw (raw)
    );

    irqc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en_i),
        .sel     (sel),
        .wr_data (wr_data_i),
        .ctrl    (ctrl)
    );

    irqc_route u_route (
        .raw    (raw),
        .ctrl   (ctrl),
        .status (status),
        .irq    (irq_o)
    );

    always_comb begin
        case (sel)
            SEL_STAT0: rd_data_o = status[0];
            SEL_STAT1: rd_data_o = status[1];
            SEL_ROUTE: rd_data_o = ctrl.route;
            SEL_RAW:   rd_data_o = raw;
            SEL_SET,
            SEL_CLR:   rd_data_o = ctrl.mask;
            default:   rd_data_o = '0;
        endcase
    end

    assert_gate_closed_R7: assert property (@(posedge clk) disable iff (rst)
        !ctrl.mask[GATE_BIT] |-> irq_o == '0);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (ctrl == '0 && irq_o == '0));
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_i = '0;
    logic [7:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic [1:0]  irq_o;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    irqc_top i_irqc_top (
        .clk(clk), .rst(rst), .src_i(src_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; addr_i = 8'h10;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic set_src(input logic [31:0] s);
        @(negedge clk);
        src_i = s;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h34, d); check("R1 mask", d, 32'h0);
        rd(8'h20, d); check("R1 route", d, 32'h0);
        check("R1 irq", {30'h0, irq_o}, 32'h0);
    endtask

    task automatic t_set();
        logic [31:0] d;
        wr(8'h34, 32'h0000_00F0);
        rd(8'h34, d); check("R2 set first", d, 32'h0000_00F0);
        wr(8'h34, 32'h0000_0003);
        rd(8'h34, d); check("R2 set accumulates", d, 32'h0000_00F3);
        wr(8'h34, 32'h0);
        rd(8'h34, d); check("R2 zero write no effect", d, 32'h0000_00F3);
        rd(8'h38, d); check("R2 read at clear offset", d, 32'h0000_00F3);
    endtask

    task automatic t_clr();
        logic [31:0] d;
        wr(8'h38, 32'h0000_0030);
        rd(8'h34, d); check("R3 partial clear", d, 32'h0000_00C3);
        wr(8'h34, 32'h8000_0000);
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h34, d); check("R3 clear all incl gate", d, 32'h0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(8'h20, 32'hA5A5_0F0F);
        rd(8'h20, d); check("R4 route readback", d, 32'hA5A5_0F0F);
    endtask

    task automatic t_raw();
        logic [31:0] d;
        set_src(32'h1234_5678);
        rd(8'h30, d); check("R5 raw unmasked", d, 32'h1234_5678);
        check("R7 no irq when masked", {30'h0, irq_o}, 32'h0);
    endtask

    task automatic t_status();
        logic [31:0] d;
        logic [31:0] m, r, s;
        m = 32'h8000_FFFF; r = 32'h0000_00F0; s = 32'h0000_0111;
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h34, m);
        wr(8'h20, r);
        set_src(s);
        rd(8'h00, d); check("R6 status0", d, s & m & ~r);
        rd(8'h04, d); check("R6 status1", d, s & m & r);
        check("R4 R7 both lines", {30'h0, irq_o}, 32'h3);
        set_src(32'h0000_0100);
        check("R4 R7 only line 0", {30'h0, irq_o}, 32'h1);
        wr(8'h38, 32'h8000_0000);
        check("R7 gate closed", {30'h0, irq_o}, 32'h0);
        rd(8'h00, d); check("R7 status kept when gated", d, 32'h0000_0100);
        wr(8'h34, 32'h8000_0000);
        check("R7 gate reopened", {30'h0, irq_o}, 32'h1);
    endtask

    task automatic t_timing();
        @(negedge clk);
        src_i = 32'h0;
        #1; check("R7 still high before edge", {31'h0, irq_o[0]}, 32'h1);
        @(negedge clk);
        check("R7 low after edge", {31'h0, irq_o[0]}, 32'h0);
        src_i = 32'h0000_0010;
        #1; check("R7 low before edge", {31'h0, irq_o[1]}, 32'h0);
        @(negedge clk);
        check("R7 line1 high after edge", {31'h0, irq_o[1]}, 32'h1);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        rd(8'h10, d); check("R8 unmapped read", d, 32'h0);
        rd(8'h3C, d); check("R8 unmapped read 3C", d, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'h0);
        wr(8'h30, 32'h1234_0000);
        wr(8'h24, 32'h5555_5555);
        rd(8'h34, d); check("R8 mask untouched", d, 32'h8000_FFFF);
        rd(8'h20, d); check("R8 route untouched", d, 32'h0000_00F0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_set();
        t_clr();
        t_route();
        t_raw();
        t_status();
        t_timing();
        t_ignored();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule